// File: doc/BRIEF.md
# Multi-source reset supervisor

This block produces one active-low system reset from four independent requests: three digital supply-fault flags (high while a supply is under its limit, supplied by external comparators) and an active-low push-button. All four requests are asynchronous to the block clock. Each passes through a two-stage synchronizer before the block acts on it. A request asserts reset at once. Reset then stays asserted until every request has cleared, and for a further recovery period after that. Any new request that arrives during the recovery period restarts it.

The push-button has an optional qualification stage. When this stage is enabled, the button must stay pressed for a programmable number of consecutive cycles before it counts as a request. A shorter press is discarded. The programmed hold never drops below a floor that is set by a parameter. The recovery period is picked at run time from three cycle counts, which are set by parameters in a ratio near 13.2 : 210 : 900. The output can drive in push-pull mode or in open-drain mode. A four-bit mask records every source that contributed to the present reset episode.

Top module: `mrst_supervisor`

## Requirements
- R1: When any supply-fault flag goes high, `rst_drv_o` goes low (push-pull mode) exactly 3 clock edges later: two synchronizer stages and one state register.
- R2: When qualification is disabled (`btn_qual_en_i`=0), pulling `btn_ni` low asserts reset after 3 clock edges, the same latency as a supply fault.
- R3: Reset releases only after every request has cleared. Release happens exactly REC+2 edges after the last request input clears, where REC is the selected recovery count.
- R4: `rec_sel_i` selects the recovery count: 2'b00 selects REC_A, 2'b01 selects REC_B, and 2'b10 or 2'b11 select REC_C.
- R5: When qualification is enabled, a press counts only after the synchronized button has been low for H consecutive cycles, with H = max(`btn_hold_i`, HOLD_MIN). Reset then asserts H+2 edges after the press begins. A shorter press leaves the output and the mask unchanged.
- R6: A `btn_hold_i` value below HOLD_MIN behaves as HOLD_MIN.
- R7: A request that arrives during the recovery countdown restarts the countdown. The new countdown begins when that request clears.
- R8: While `rst_ni` is low, reset is asserted and the mask is zero. After `rst_ni` rises, the first release comes REC edges later.
- R9: In push-pull mode (`od_mode_i`=0), `rst_oe_o`=1 and `rst_drv_o` is the inverted reset state. In open-drain mode, `rst_drv_o`=0 and `rst_oe_o` is high only while reset is asserted.
- R10: In `cause_o`, bit0 is the primary fault, bit1 the secondary fault, bit2 the tertiary fault and bit3 the qualified button. The bits accumulate during a reset episode and are zero whenever reset is not asserted.
- R11: If a request reaches the state register in the same cycle that the recovery count expires, the request wins and reset stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| sup1_low_i | input | 1 | Primary supply below limit (async) |
| sup2_low_i | input | 1 | Secondary supply below limit (async) |
| sup3_low_i | input | 1 | Tertiary supply below limit (async) |
| btn_ni | input | 1 | Push-button, low when pressed (async) |
| btn_qual_en_i | input | 1 | Enables the button hold qualification |
| btn_hold_i | input | HOLD_W | Required hold length in cycles |
| rec_sel_i | input | 2 | Recovery length select |
| od_mode_i | input | 1 | 1 selects open-drain drive |
| rst_drv_o | output | 1 | Driven reset level, active low |
| rst_oe_o | output | 1 | Output drive enable |
| cause_o | output | 4 | Sticky mask of sources in the current episode |

## Verification
Two functions can meet in one cycle: the recovery countdown reaching its last count, and a fresh request arriving at the state register. The bench provokes this by clearing a fault and then raising a different fault exactly REC-1 edges later. Its synchronized copy then lands on the terminal cycle. The bench judges the result by requiring `rst_drv_o` to stay low at REC+2 and the mask to hold both sources. A second case puts two flags in the same cycle and checks that both bits of the mask are set.

// File: rtl/mrst_pkg.sv
package mrst_pkg;
    localparam int NSRC    = 4;
    localparam int SRC_P   = 0;
    localparam int SRC_S   = 1;
    localparam int SRC_T   = 2;
    localparam int SRC_BTN = 3;

    typedef enum logic [1:0] {
        REC_SHORT    = 2'b00,
        REC_MID      = 2'b01,
        REC_LONG     = 2'b10,
        REC_LONG_ALT = 2'b11
    } rec_sel_e;

    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/mrst_sync.sv
module mrst_sync #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/mrst_btn_qual.sv
module mrst_btn_qual #(
    parameter int HOLD_W   = 24,
    parameter int HOLD_MIN = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              btn_low_i,
    input  logic              en_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              qual_o
);
    localparam int              MIN_EFF = (HOLD_MIN < 1) ? 1 : HOLD_MIN;
    localparam logic [HOLD_W-1:0] MIN_L = HOLD_W'(MIN_EFF);

    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
    } qual_t;

    qual_t             st_d, st_q;
    logic [HOLD_W-1:0] eff_hold;
    logic [HOLD_W-1:0] hold_last;

    always_comb begin
        eff_hold  = (hold_i < MIN_L) ? MIN_L : hold_i;
        hold_last = eff_hold - 1'b1;
        st_d      = st_q;
        if (!btn_low_i || !en_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < eff_hold) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (!en_i) begin
            qual_o = btn_low_i;
        end else begin
            qual_o = btn_low_i && (st_q.cnt >= hold_last);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    qual_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && $rose(qual_o) && (MIN_EFF > 1)) |-> $past(btn_low_i));

    // R6
    qual_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && qual_o) |-> (st_q.cnt >= MIN_L - 1'b1));
endmodule

// File: rtl/mrst_stretch.sv
module mrst_stretch
    import mrst_pkg::*;
#(
    parameter int REC_A = 132,
    parameter int REC_B = 2100,
    parameter int REC_C = 9000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  src_vec_t   src_i,
    input  logic [1:0] sel_i,
    output logic       asserted_o,
    output src_vec_t   cause_o
);
    localparam int REC_W = $clog2(REC_C + 1) + 1;

    typedef struct packed {
        logic             asserted;
        logic [REC_W-1:0] cnt;
        src_vec_t         cause;
    } str_t;

    str_t             st_d, st_q;
    logic [REC_W-1:0] rec_len;
    logic [REC_W-1:0] rec_last;

    always_comb begin
        case (rec_sel_e'(sel_i))
            REC_SHORT: rec_len = REC_W'(REC_A);
            REC_MID:   rec_len = REC_W'(REC_B);
            default:   rec_len = REC_W'(REC_C);
        endcase
        rec_last = rec_len - 1'b1;
        st_d     = st_q;
        if (|src_i) begin
            st_d.asserted = 1'b1;
            st_d.cnt      = '0;
            st_d.cause    = st_q.cause | src_i;
        end else if (st_q.asserted) begin
            if (st_q.cnt >= rec_last) begin
                st_d.asserted = 1'b0;
                st_d.cnt      = '0;
                st_d.cause    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{asserted: 1'b1, cnt: '0, cause: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign asserted_o = st_q.asserted;
    assign cause_o    = st_q.cause;

    // R1
    src_forces_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|src_i) |=> st_q.asserted);

    // R3
    quiet_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.asserted) |-> $past(src_i == '0));

    // R10
    cause_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.asserted |-> (st_q.cause == '0));

    // R10
    cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(st_q.asserted) && st_q.asserted) |->
            ((st_q.cause & $past(st_q.cause)) == $past(st_q.cause)));

    // R4
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < REC_W'(REC_C));
endmodule

// File: rtl/mrst_supervisor.sv
module mrst_supervisor
    import mrst_pkg::*;
#(
    parameter int REC_A    = 132,
    parameter int REC_B    = 2100,
    parameter int REC_C    = 9000,
    parameter int HOLD_W   = 24,
    parameter int HOLD_MIN = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sup1_low_i,
    input  logic              sup2_low_i,
    input  logic              sup3_low_i,
    input  logic              btn_ni,
    input  logic              btn_qual_en_i,
    input  logic [HOLD_W-1:0] btn_hold_i,
    input  logic [1:0]        rec_sel_i,
    input  logic              od_mode_i,
    output logic              rst_drv_o,
    output logic              rst_oe_o,
    output logic [NSRC-1:0]   cause_o
);
    localparam src_vec_t SYNC_IDLE = src_vec_t'(1) << SRC_BTN;

    src_vec_t raw_in, synced, src_vec;
    logic     btn_qual;
    logic     asserted;

    assign raw_in = {btn_ni, sup3_low_i, sup2_low_i, sup1_low_i};

    mrst_sync #(.W(NSRC), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_in),
        .q_o    (synced)
    );

    mrst_btn_qual #(.HOLD_W(HOLD_W), .HOLD_MIN(HOLD_MIN)) u_qual (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .btn_low_i (!synced[SRC_BTN]),
        .en_i      (btn_qual_en_i),
        .hold_i    (btn_hold_i),
        .qual_o    (btn_qual)
    );

    always_comb begin
        src_vec          = synced;
        src_vec[SRC_BTN] = btn_qual;
    end

    mrst_stretch #(.REC_A(REC_A), .REC_B(REC_B), .REC_C(REC_C)) u_stretch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_vec),
        .sel_i      (rec_sel_i),
        .asserted_o (asserted),
        .cause_o    (cause_o)
    );

    always_comb begin
        if (od_mode_i) begin
            rst_drv_o = 1'b0;
            rst_oe_o  = asserted;
        end else begin
            rst_drv_o = !asserted;
            rst_oe_o  = 1'b1;
        end
    end

    // R9
    drive_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_o != '0) |-> (!rst_drv_o && rst_oe_o == !od_mode_i || !rst_drv_o && rst_oe_o));
endmodule

// File: tb/mrst_supervisor_bench.sv
`timescale 1ns/1ps
module mrst_supervisor_bench;
    localparam int RA = 13;
    localparam int RB = 210;
    localparam int RC = 900;
    localparam int HW = 8;
    localparam int HMIN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s1 = 1'b0, s2 = 1'b0, s3 = 1'b0, btn_n = 1'b1;
    logic          qen = 1'b0;
    logic [HW-1:0] hold = '0;
    logic [1:0]    sel = 2'b00;
    logic          od = 1'b0;
    logic          drv, oe;
    logic [3:0]    cause;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mrst_supervisor #(.REC_A(RA), .REC_B(RB), .REC_C(RC), .HOLD_W(HW), .HOLD_MIN(HMIN)) u_mrst_supervisor (
        .clk_i(clk), .rst_ni(rst_n), .sup1_low_i(s1), .sup2_low_i(s2), .sup3_low_i(s3),
        .btn_ni(btn_n), .btn_qual_en_i(qen), .btn_hold_i(hold), .rec_sel_i(sel),
        .od_mode_i(od), .rst_drv_o(drv), .rst_oe_o(oe), .cause_o(cause)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // R3: release REC+2 edges after the last request clears
    task automatic exp_release(input int rec, input string req);
        step(rec + 1);
        chk(req, "still held", drv, 0);
        step(1);
        chk(req, "released", drv, 1);
        chk("R10", "mask cleared", cause, 0);
    endtask

    // R8
    task automatic t_power_on();
        step(3);
        chk("R8", "drv in reset", drv, 0);
        chk("R8", "oe in reset", oe, 1);
        chk("R8", "mask in reset", cause, 0);
        rst_n = 1'b1;
        step(RA - 1);
        chk("R8", "held before first release", drv, 0);
        step(1);
        chk("R8", "first release", drv, 1);
    endtask

    // R1 R10
    task automatic t_fault(input int idx);
        if (idx == 0) s1 = 1'b1; else if (idx == 1) s2 = 1'b1; else s3 = 1'b1;
        step(2);
        chk("R1", "not yet asserted", drv, 1);
        step(1);
        chk("R1", "asserted", drv, 0);
        chk("R10", "mask bit", cause, 1 << idx);
        s1 = 1'b0; s2 = 1'b0; s3 = 1'b0;
        exp_release(RA, "R3");
    endtask

    // R2
    task automatic t_btn_direct();
        qen = 1'b0;
        btn_n = 1'b0;
        step(2);
        chk("R2", "not yet asserted", drv, 1);
        step(1);
        chk("R2", "asserted", drv, 0);
        chk("R10", "button bit", cause, 8);
        btn_n = 1'b1;
        exp_release(RA, "R2");
    endtask

    // R5
    task automatic t_qual();
        qen = 1'b1;
        hold = 8'd10;
        btn_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step(1);
            chk("R5", "short press ignored", drv, 1);
        end
        btn_n = 1'b1;
        step(6);
        chk("R5", "after short press", drv, 1);
        chk("R5", "mask after short press", cause, 0);
        btn_n = 1'b0;
        step(11);
        chk("R5", "before hold done", drv, 1);
        step(1);
        chk("R5", "hold done", drv, 0);
        chk("R5", "button bit", cause, 8);
        btn_n = 1'b1;
        exp_release(RA, "R5");
    endtask

    // R6
    task automatic t_min_hold();
        qen = 1'b1;
        hold = 8'd1;
        btn_n = 1'b0;
        step(3);
        btn_n = 1'b1;
        step(6);
        chk("R6", "3-cycle press ignored", drv, 1);
        btn_n = 1'b0;
        step(HMIN + 1);
        chk("R6", "before floor", drv, 1);
        step(1);
        chk("R6", "at floor", drv, 0);
        btn_n = 1'b1;
        exp_release(RA, "R6");
        qen = 1'b0;
    endtask

    // R7
    task automatic t_restart();
        s1 = 1'b1;
        step(3);
        s1 = 1'b0;
        step(5);
        s2 = 1'b1;
        step(1);
        s2 = 1'b0;
        step(3);
        chk("R7", "mask both", cause, 3);
        step(RA + 1 - 3);
        chk("R7", "restarted, held", drv, 0);
        step(1);
        chk("R7", "released", drv, 1);
    endtask

    // R4
    task automatic t_sel(input logic [1:0] v, input int rec);
        sel = v;
        s3 = 1'b1;
        step(3);
        s3 = 1'b0;
        exp_release(rec, "R4");
        sel = 2'b00;
    endtask

    // R9
    task automatic t_od();
        od = 1'b1;
        step(1);
        chk("R9", "od idle drv", drv, 0);
        chk("R9", "od idle oe", oe, 0);
        s1 = 1'b1;
        step(3);
        chk("R9", "od asserted oe", oe, 1);
        chk("R9", "od asserted drv", drv, 0);
        s1 = 1'b0;
        step(RA + 1);
        chk("R9", "od held oe", oe, 1);
        step(1);
        chk("R9", "od released oe", oe, 0);
        od = 1'b0;
        step(1);
        chk("R9", "pp idle drv", drv, 1);
        chk("R9", "pp idle oe", oe, 1);
    endtask

    // R11 R10
    task automatic t_collide();
        s1 = 1'b1;
        s2 = 1'b1;
        step(3);
        chk("R10", "two flags same cycle", cause, 3);
        s1 = 1'b0;
        s2 = 1'b0;
        exp_release(RA, "R3");
        s3 = 1'b1;
        step(3);
        s3 = 1'b0;
        step(RA - 1);
        s1 = 1'b1;
        step(3);
        chk("R11", "request wins terminal cycle", drv, 0);
        chk("R11", "mask kept", cause, 5);
        s1 = 1'b0;
        exp_release(RA, "R11");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_power_on();
        t_fault(0);
        t_fault(1);
        t_fault(2);
        t_btn_direct();
        t_qual();
        t_min_hold();
        t_restart();
        t_sel(2'b01, RB);
        t_sel(2'b10, RC);
        t_sel(2'b11, RC);
        t_od();
        t_collide();
        summary();
        $finish;
    end
endmodule